// File: doc/BRIEF.md
# Second-Operand Shifter and Rotated-Immediate Generator

This block forms the second operand that a 32-bit data-processing ALU consumes, together with the shifter carry-out that the ALU may place in its carry flag. It has two modes. In register mode it takes a register value and applies one of four shift kinds. The shift count is either a small immediate count or the low byte of another register. In immediate mode it widens an 8-bit constant to 32 bits and rotates it right by twice a 4-bit rotate field.

Operations arrive on a valid/ready input stream and leave on a valid/ready output stream through one output register. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result appears on `out_operand`/`out_carry` with `out_valid` high from the next edge on. While `out_valid` is high and `out_ready` is low, the output holds its value and no new operation is accepted. The carry input `in_carry` is the ALU's current carry flag. Instruction decode and the register file sit outside the block.

Top module: `op2_shifter`

## Requirements
- R1: Shift kind encoding on `in_shtype` is 00 left logical, 01 right logical, 10 right arithmetic, 11 rotate right. In register mode with `in_amt_from_reg`=0, the count is `in_amt_imm` (0..31). A left logical shift by n in 1..31 gives `in_rm << n` with carry `in_rm[32-n]`.
- R2: A right logical or right arithmetic shift by n in 1..31 gives the shifted value, zero-filled or sign-filled, with carry `in_rm[n-1]`.
- R3: A rotate right by n in 1..31 gives the rotated value, with carry equal to bit 31 of the result.
- R4: With `in_amt_from_reg`=1, the count is the unsigned 8-bit value `in_amt_reg` (0..255). For counts 1..31 all four kinds behave as in R1 to R3.
- R5: A count of zero, from either source, passes `in_rm` through unchanged and passes `in_carry` through to `out_carry`.
- R6: A count of exactly 32 gives zero for both logical shifts, with carry `in_rm[0]` for left and `in_rm[31]` for right. A count above 32 gives zero with carry 0.
- R7: A right arithmetic shift by 32 or more gives 32 copies of `in_rm[31]`, with that bit as carry.
- R8: A rotate by a nonzero multiple of 32 leaves the value unchanged, with carry `in_rm[31]`.
- R9: With `in_imm_mode`=1, the result is `in_imm8` zero-extended and rotated right by 2×`in_rot`. Shift kind and count inputs are ignored. Carry is `in_carry` when `in_rot`=0 and bit 31 of the result otherwise.
- R10: `in_ready` is high exactly when the output is empty or `out_ready` is high. An accepted operation appears with `out_valid` one edge later. A stalled output holds its value and carry.
- R11: After reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted |
| in_imm_mode | input | 1 | 1 = rotated immediate, 0 = shifted register |
| in_shtype | input | 2 | Shift kind (00 LSL, 01 LSR, 10 ASR, 11 ROR) |
| in_amt_from_reg | input | 1 | 1 = count from register byte, 0 = immediate count |
| in_amt_imm | input | 5 | Immediate shift count |
| in_amt_reg | input | 8 | Low byte of the count register |
| in_rm | input | 32 | Register value to shift |
| in_imm8 | input | 8 | Immediate constant |
| in_rot | input | 4 | Rotate field (rotation is twice this value) |
| in_carry | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes the result |
| out_operand | output | 32 | Second operand |
| out_carry | output | 1 | Shifter carry-out |

## Verification
The bench builds the block with its default parameters: 32-bit data, an 8-bit immediate, a 4-bit rotate field and an 8-bit register count. With these values every immediate count 0..31 and every rotate field value can be swept exhaustively. The register byte also reaches the boundary counts 32 and 33 and the top value 255, and it reaches rotate multiples of 32. Back-pressure is applied with a second operation waiting, so both the hold behaviour and simultaneous drain-and-accept are exercised.

// File: rtl/op2_pkg.sv
package op2_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shift_kind_e;
endpackage

// File: rtl/op2_amount_sel.sv
module op2_amount_sel
  import op2_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ROT_W    = 4,
  parameter int REGAMT_W = 8,
  localparam int CNT_W   = $clog2(DATA_W)
) (
  input  logic                imm_mode,
  input  logic                from_reg,
  input  shift_kind_e         kind_in,
  input  logic [CNT_W-1:0]    amt_imm,
  input  logic [REGAMT_W-1:0] amt_reg,
  input  logic [ROT_W-1:0]    rot,
  output shift_kind_e         kind_eff,
  output logic [CNT_W-1:0]    count_lo,
  output logic                cnt_zero,
  output logic                cnt_eq,
  output logic                cnt_over
);
  localparam int CW = REGAMT_W + 1;
  localparam logic [CW-1:0] LIMIT = CW'(DATA_W);

  logic [REGAMT_W-1:0] count_full;

  always_comb begin
    if (imm_mode)
      count_full = REGAMT_W'({rot, 1'b0});
    else if (from_reg)
      count_full = amt_reg;
    else
      count_full = REGAMT_W'(amt_imm);
  end

  assign kind_eff = imm_mode ? SH_ROR : kind_in;
  assign count_lo = count_full[CNT_W-1:0];
  assign cnt_zero = (count_full == '0);
  assign cnt_eq   = ({1'b0, count_full} == LIMIT);
  assign cnt_over = ({1'b0, count_full} > LIMIT);
endmodule

// File: rtl/op2_barrel.sv
module op2_barrel
  import op2_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] src,
  input  shift_kind_e       kind,
  input  logic [CNT_W-1:0]  amt,
  output logic [DATA_W-1:0] dst
);
  function automatic logic [DATA_W-1:0] step(input logic [DATA_W-1:0] d,
                                             input shift_kind_e k,
                                             input int n);
    logic [DATA_W-1:0] r;
    case (k)
      SH_LSL:  r = d << n;
      SH_LSR:  r = d >> n;
      SH_ASR:  r = DATA_W'($signed(d) >>> n);
      default: r = (d >> n) | (d << (DATA_W - n));
    endcase
    return r;
  endfunction

  logic [DATA_W-1:0] stage [0:CNT_W];
  assign stage[0] = src;

  for (genvar s = 0; s < CNT_W; s++) begin : g_stage
    localparam int K = 1 << s;
    assign stage[s+1] = amt[s] ? step(stage[s], kind, K) : stage[s];
  end

  assign dst = stage[CNT_W];
endmodule

// File: rtl/op2_result_sel.sv
module op2_result_sel
  import op2_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] shifted,
  input  shift_kind_e       kind,
  input  logic [CNT_W-1:0]  count_lo,
  input  logic              cnt_zero,
  input  logic              cnt_eq,
  input  logic              cnt_over,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  localparam int MSB = DATA_W - 1;

  logic [CNT_W-1:0] idx_left;
  logic [CNT_W-1:0] idx_right;

  assign idx_left  = CNT_W'(0) - count_lo;
  assign idx_right = count_lo - CNT_W'(1);

  always_comb begin
    res  = shifted;
    cout = cin;
    if (cnt_zero) begin
      res  = src;
      cout = cin;
    end else begin
      case (kind)
        SH_LSL: begin
          if (cnt_over)    begin res = '0; cout = 1'b0;   end
          else if (cnt_eq) begin res = '0; cout = src[0]; end
          else             begin res = shifted; cout = src[idx_left]; end
        end
        SH_LSR: begin
          if (cnt_over)    begin res = '0; cout = 1'b0;     end
          else if (cnt_eq) begin res = '0; cout = src[MSB]; end
          else             begin res = shifted; cout = src[idx_right]; end
        end
        SH_ASR: begin
          if (cnt_over || cnt_eq) begin
            res  = {DATA_W{src[MSB]}};
            cout = src[MSB];
          end else begin
            res  = shifted;
            cout = src[idx_right];
          end
        end
        default: begin
          if (count_lo == '0) begin
            res  = src;
            cout = src[MSB];
          end else begin
            res  = shifted;
            cout = shifted[MSB];
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/op2_shifter.sv
module op2_shifter
  import op2_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int IMM_W    = 8,
  parameter int ROT_W    = 4,
  parameter int REGAMT_W = 8,
  localparam int CNT_W   = $clog2(DATA_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                in_imm_mode,
  input  logic [1:0]          in_shtype,
  input  logic                in_amt_from_reg,
  input  logic [CNT_W-1:0]    in_amt_imm,
  input  logic [REGAMT_W-1:0] in_amt_reg,
  input  logic [DATA_W-1:0]   in_rm,
  input  logic [IMM_W-1:0]    in_imm8,
  input  logic [ROT_W-1:0]    in_rot,
  input  logic                in_carry,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [DATA_W-1:0]   out_operand,
  output logic                out_carry
);
  shift_kind_e       kind_eff;
  logic [CNT_W-1:0]  count_lo;
  logic              cnt_zero, cnt_eq, cnt_over;
  logic [DATA_W-1:0] src;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] res;
  logic              cout;
  logic              accept;

  logic              valid_q;
  logic [DATA_W-1:0] data_q;
  logic              carry_q;

  assign src = in_imm_mode ? DATA_W'(in_imm8) : in_rm;

  op2_amount_sel #(
    .DATA_W(DATA_W), .ROT_W(ROT_W), .REGAMT_W(REGAMT_W)
  ) u_amt (
    .imm_mode (in_imm_mode),
    .from_reg (in_amt_from_reg),
    .kind_in  (shift_kind_e'(in_shtype)),
    .amt_imm  (in_amt_imm),
    .amt_reg  (in_amt_reg),
    .rot      (in_rot),
    .kind_eff (kind_eff),
    .count_lo (count_lo),
    .cnt_zero (cnt_zero),
    .cnt_eq   (cnt_eq),
    .cnt_over (cnt_over)
  );

  op2_barrel #(.DATA_W(DATA_W)) u_bar (
    .src  (src),
    .kind (kind_eff),
    .amt  (count_lo),
    .dst  (shifted)
  );

  op2_result_sel #(.DATA_W(DATA_W)) u_sel (
    .src      (src),
    .shifted  (shifted),
    .kind     (kind_eff),
    .count_lo (count_lo),
    .cnt_zero (cnt_zero),
    .cnt_eq   (cnt_eq),
    .cnt_over (cnt_over),
    .cin      (in_carry),
    .res      (res),
    .cout     (cout)
  );

  assign in_ready = !valid_q || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      carry_q <= 1'b0;
    end else if (accept) begin
      valid_q <= 1'b1;
      data_q  <= res;
      carry_q <= cout;
    end else if (out_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign out_valid   = valid_q;
  assign out_operand = data_q;
  assign out_carry   = carry_q;
endmodule

// File: rtl/op2_shifter_chk.sv
module op2_shifter_chk #(
  parameter int DATA_W   = 32,
  parameter int IMM_W    = 8,
  parameter int ROT_W    = 4,
  parameter int REGAMT_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic                in_imm_mode,
  input logic [1:0]          in_shtype,
  input logic                in_amt_from_reg,
  input logic [REGAMT_W-1:0] in_amt_reg,
  input logic [DATA_W-1:0]   in_rm,
  input logic [IMM_W-1:0]    in_imm8,
  input logic [ROT_W-1:0]    in_rot,
  input logic                in_carry,
  input logic                out_valid,
  input logic                out_ready,
  input logic [DATA_W-1:0]   out_operand,
  input logic                out_carry
);
  localparam logic [REGAMT_W-1:0] LIM = REGAMT_W'(DATA_W);
  logic take, reg_cnt;
  assign take    = in_valid && in_ready;
  assign reg_cnt = take && !in_imm_mode && in_amt_from_reg;

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_operand) && $stable(out_carry)));

  // R10
  accept_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  // R11
  idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !in_valid) |=> !out_valid);

  // R9
  imm_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_imm_mode && in_rot != '0) |=> (out_carry == out_operand[DATA_W-1]));

  // R9
  imm_norot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_imm_mode && in_rot == '0) |=>
      (out_operand == DATA_W'($past(in_imm8)) && out_carry == $past(in_carry)));

  // R5
  zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_cnt && in_amt_reg == '0) |=>
      (out_operand == $past(in_rm) && out_carry == $past(in_carry)));

  // R6
  lsl_big_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_cnt && in_shtype == 2'b00 && in_amt_reg >= LIM) |=> (out_operand == '0));

  // R7
  asr_big_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_cnt && in_shtype == 2'b10 && in_amt_reg >= LIM) |=>
      (out_operand == {DATA_W{$past(in_rm[DATA_W-1])}} && out_carry == $past(in_rm[DATA_W-1])));
endmodule

bind op2_shifter op2_shifter_chk #(
  .DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W), .REGAMT_W(REGAMT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_imm_mode(in_imm_mode), .in_shtype(in_shtype), .in_amt_from_reg(in_amt_from_reg),
  .in_amt_reg(in_amt_reg), .in_rm(in_rm), .in_imm8(in_imm8), .in_rot(in_rot),
  .in_carry(in_carry), .out_valid(out_valid), .out_ready(out_ready),
  .out_operand(out_operand), .out_carry(out_carry)
);

// File: tb/sim_op2_shifter.sv
module sim_op2_shifter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_imm_mode = 1'b0;
  logic [1:0]  in_shtype = 2'b00;
  logic        in_amt_from_reg = 1'b0;
  logic [4:0]  in_amt_imm = '0;
  logic [7:0]  in_amt_reg = '0;
  logic [31:0] in_rm = '0;
  logic [7:0]  in_imm8 = '0;
  logic [3:0]  in_rot = '0;
  logic        in_carry = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_operand;
  logic        out_carry;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  op2_shifter u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_imm_mode(in_imm_mode), .in_shtype(in_shtype), .in_amt_from_reg(in_amt_from_reg),
    .in_amt_imm(in_amt_imm), .in_amt_reg(in_amt_reg), .in_rm(in_rm),
    .in_imm8(in_imm8), .in_rot(in_rot), .in_carry(in_carry),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_operand(out_operand), .out_carry(out_carry)
  );

  // Expected {carry, operand} from the requirements.
  function automatic logic [32:0] model(input logic imm, input logic [1:0] k_in,
      input logic fr, input logic [4:0] a5, input logic [7:0] ab,
      input logic [31:0] x, input logic [7:0] i8, input logic [3:0] r, input logic cin);
    int n, m;
    logic [1:0] k;
    logic [31:0] v, res;
    logic c;
    if (imm) begin v = {24'd0, i8}; n = 2 * int'(r); k = 2'b11; end
    else begin v = x; n = fr ? int'(ab) : int'(a5); k = k_in; end
    if (n == 0) return {cin, v};
    case (k)
      2'b00: if (n < 32) begin res = v << n; c = v[32-n]; end
             else if (n == 32) begin res = '0; c = v[0]; end
             else begin res = '0; c = 1'b0; end
      2'b01: if (n < 32) begin res = v >> n; c = v[n-1]; end
             else if (n == 32) begin res = '0; c = v[31]; end
             else begin res = '0; c = 1'b0; end
      2'b10: if (n < 32) begin res = 32'($signed(v) >>> n); c = v[n-1]; end
             else begin res = {32{v[31]}}; c = v[31]; end
      default: begin
        m = n % 32;
        if (m == 0) begin res = v; c = v[31]; end
        else begin res = (v >> m) | (v << (32 - m)); c = res[31]; end
      end
    endcase
    return {c, res};
  endfunction

  task automatic check(input string tag, input logic [32:0] act, input logic [32:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual carry=%0b op=%08h expected carry=%0b op=%08h",
               tag, act[32], act[31:0], exp[32], exp[31:0]);
    end
  endtask

  // Drive one operation, let it pass the output register, compare.
  task automatic run_op(input string tag, input logic imm, input logic [1:0] k,
      input logic fr, input logic [4:0] a5, input logic [7:0] ab, input logic [31:0] x,
      input logic [7:0] i8, input logic [3:0] r, input logic cin);
    @(negedge clk);
    in_imm_mode = imm; in_shtype = k; in_amt_from_reg = fr; in_amt_imm = a5;
    in_amt_reg = ab; in_rm = x; in_imm8 = i8; in_rot = r; in_carry = cin;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, {out_carry, out_operand}, model(imm, k, fr, a5, ab, x, i8, r, cin));
  endtask

  task automatic t_reset;
    n_tests++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL R11: actual valid=%0b ready=%0b expected valid=0 ready=1", out_valid, in_ready);
    end
  endtask

  task automatic t_lsl_imm;
    for (int n = 0; n < 32; n++)
      run_op(n == 0 ? "R5 imm count zero" : "R1 lsl imm", 1'b0, 2'b00, 1'b0, 5'(n), 8'hFF,
             32'h8000_0003 ^ (32'h1 << n), 8'h00, 4'h0, n[0]);
  endtask

  task automatic t_right_imm;
    for (int n = 1; n < 32; n++) begin
      run_op("R2 lsr imm", 1'b0, 2'b01, 1'b0, 5'(n), 8'h00, 32'hF0F0_5A5A ^ 32'(n), 8'h00, 4'h0, 1'b0);
      run_op("R2 asr imm", 1'b0, 2'b10, 1'b0, 5'(n), 8'h00, 32'h9123_4567 + 32'(n), 8'h00, 4'h0, 1'b1);
    end
  endtask

  task automatic t_ror_imm;
    for (int n = 1; n < 32; n++)
      run_op("R3 ror imm", 1'b0, 2'b11, 1'b0, 5'(n), 8'h00, 32'h0000_0001 << (n - 1), 8'h00, 4'h0, 1'b0);
  endtask

  task automatic t_reg_count;
    run_op("R4 lsl reg 7", 1'b0, 2'b00, 1'b1, 5'd0, 8'd7, 32'h0300_00F1, 8'h00, 4'h0, 1'b0);
    run_op("R4 lsr reg 31", 1'b0, 2'b01, 1'b1, 5'd3, 8'd31, 32'hC000_0000, 8'h00, 4'h0, 1'b0);
    run_op("R4 asr reg 4", 1'b0, 2'b10, 1'b1, 5'd9, 8'd4, 32'h8000_0018, 8'h00, 4'h0, 1'b0);
    run_op("R4 ror reg 12", 1'b0, 2'b11, 1'b1, 5'd0, 8'd12, 32'h0000_0ABC, 8'h00, 4'h0, 1'b1);
    run_op("R5 reg zero carry1", 1'b0, 2'b01, 1'b1, 5'd17, 8'd0, 32'hDEAD_BEEF, 8'h00, 4'h0, 1'b1);
    run_op("R5 reg zero carry0", 1'b0, 2'b10, 1'b1, 5'd17, 8'd0, 32'h8000_0001, 8'h00, 4'h0, 1'b0);
  endtask

  task automatic t_reg_big;
    run_op("R6 lsl 32", 1'b0, 2'b00, 1'b1, 5'd0, 8'd32, 32'h0000_0001, 8'h00, 4'h0, 1'b0);
    run_op("R6 lsl 33", 1'b0, 2'b00, 1'b1, 5'd0, 8'd33, 32'hFFFF_FFFF, 8'h00, 4'h0, 1'b1);
    run_op("R6 lsr 32", 1'b0, 2'b01, 1'b1, 5'd0, 8'd32, 32'h8000_0000, 8'h00, 4'h0, 1'b0);
    run_op("R6 lsr 255", 1'b0, 2'b01, 1'b1, 5'd0, 8'd255, 32'hFFFF_FFFF, 8'h00, 4'h0, 1'b1);
    run_op("R7 asr 32 neg", 1'b0, 2'b10, 1'b1, 5'd0, 8'd32, 32'h8000_0000, 8'h00, 4'h0, 1'b0);
    run_op("R7 asr 200 pos", 1'b0, 2'b10, 1'b1, 5'd0, 8'd200, 32'h7FFF_FFFF, 8'h00, 4'h0, 1'b1);
  endtask

  task automatic t_ror_reg;
    run_op("R8 ror 32", 1'b0, 2'b11, 1'b1, 5'd0, 8'd32, 32'h8765_4321, 8'h00, 4'h0, 1'b0);
    run_op("R8 ror 64", 1'b0, 2'b11, 1'b1, 5'd0, 8'd64, 32'h1234_5678, 8'h00, 4'h0, 1'b1);
    run_op("R8 ror 36", 1'b0, 2'b11, 1'b1, 5'd0, 8'd36, 32'h0000_000F, 8'h00, 4'h0, 1'b0);
  endtask

  task automatic t_immediate;
    for (int r = 0; r < 16; r++) begin
      run_op("R9 imm rot", 1'b1, 2'(r), 1'b1, 5'(r), 8'(r * 3), 32'hFFFF_FFFF, 8'hB5, 4'(r), r[0]);
      run_op("R9 imm rot c", 1'b1, 2'b00, 1'b0, 5'd5, 8'd40, 32'h0, 8'hFF, 4'(r), ~r[0]);
    end
  endtask

  task automatic t_backpressure;
    logic [32:0] exp_a, exp_b;
    exp_a = model(1'b0, 2'b00, 1'b0, 5'd4, 8'd0, 32'h0000_1234, 8'h00, 4'h0, 1'b0);
    exp_b = model(1'b0, 2'b01, 1'b0, 5'd8, 8'd0, 32'hAB00_0000, 8'h00, 4'h0, 1'b0);
    @(negedge clk);
    out_ready = 1'b0;
    in_imm_mode = 1'b0; in_shtype = 2'b00; in_amt_from_reg = 1'b0; in_amt_imm = 5'd4;
    in_rm = 32'h0000_1234; in_carry = 1'b0; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R10 first held", {out_carry, out_operand}, exp_a);
    in_shtype = 2'b01; in_amt_imm = 5'd8; in_rm = 32'hAB00_0000;
    n_tests++;
    if (in_ready !== 1'b0 || out_valid !== 1'b1) begin
      n_fail++;
      $display("FAIL R10: actual ready=%0b valid=%0b expected ready=0 valid=1", in_ready, out_valid);
    end
    @(posedge clk);
    @(negedge clk);
    check("R10 stall holds", {out_carry, out_operand}, exp_a);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 drain and accept", {out_carry, out_operand}, exp_b);
    @(posedge clk);
    @(negedge clk);
    n_tests++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R10: actual valid=%0b expected valid=0 after drain", out_valid);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lsl_imm();
    t_right_imm();
    t_ror_imm();
    t_reg_count();
    t_reg_big();
    t_ror_reg();
    t_immediate();
    t_backpressure();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule